// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block recovers a short reply from a device that answers on a load-modulated subcarrier. The reply has no start marker, no stop marker and no length field. The receiver must therefore be told in advance how many bits to collect. Reception is locked to the moment the local transmitter finishes its own frame, which the surrounding logic marks with a `start` pulse.

After `start`, the block waits a fixed number of time-base ticks. It then splits time into back-to-back bit windows of equal length. In every window it counts level changes, both rising and falling, on a hysteresis-sliced input. That input first passes through a two-flop synchronizer. A window whose count falls inside an open numeric band reads as 1, and every other count reads as 0. A silent line and an all-zero reply therefore look the same. Bits enter the result word lowest bit first. `done` pulses once when the last window closes.

The time base is a tick-enable input, so the same block runs from any clock as long as the tick rate gives the intended window length. Transitions are counted on every clock cycle inside a window, not only on tick cycles.

Top module: `edge_tally_rx`

## Requirements
- R1: While reset is held and on the first cycle after it, `done_o` is 0, `data_o` is 0 and `nbits_o` is 0.
- R2: With `tick_en` held high, a frame of L bits (L from 1 to 16) starts on the clock edge E that samples `start`. The first window begins 490 ticks after E. Each window lasts 150 ticks with no gap between windows. `done_o` goes high for one cycle directly after edge E+490+150·L.
- R3: A window counts as bit 1 when its transition count is strictly greater than 20 and strictly less than 60; it reads as 0 otherwise, so counts of 0, 20 and 60 each read as 0, and counts of 21, 42 and 59 each read as 1.
- R4: The bit from window i (counting from 0) lands in `data_o[i]`, lowest bit first.
- R5: `req_bits` values above 16 are clamped to 16, and `nbits_o` reports the clamped length from the cycle after `start`. A request of 0 opens no window, and `done_o` pulses on the cycle after `start` with `data_o` equal to 0.
- R6: Transitions before the first window opens (during the wait) have no effect on any bit.
- R7: `done_o` is a single-cycle pulse, issued once per frame. `data_o` and `nbits_o` hold their values until the next accepted `start`.
- R8: Bits of `data_o` at and above the requested length read as 0.
- R9: A `start` pulse while a frame is in progress is ignored, and the frame finishes at its original time with its original data.
- R10: Wait and window timing advance only on cycles with `tick_en` high. At half tick rate, the bits are still decoded correctly.
- R11: The per-window count saturates at its maximum (63 by default), so a window with 100 transitions reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle pulse marking the end of the outgoing frame |
| req_bits | input | 5 | Number of reply bits wanted (clamped to 16) |
| tick_en | input | 1 | Time-base enable; one tick per high cycle |
| rx_in | input | 1 | Hysteresis-sliced receive level (asynchronous) |
| data_o | output | 16 | Received word, window 0 in bit 0 |
| nbits_o | output | 5 | Clamped length of the current/last frame |
| done_o | output | 1 | One-cycle pulse after the final window |

## Verification
The assertions assume that `start` arrives as isolated pulses. They also assume that `rx_in` changes in step with the clock, so that each level change becomes exactly one counted edge after the synchronizer. The stimulus changes `rx_in` and `start` only on falling clock edges. It places every burst of transitions at least ten cycles inside its window, which keeps the three-cycle synchronizer delay from pushing an edge across a window boundary. At half tick rate the window edges drift by at most one cycle, so the same margins still hold.

// File: rtl/edge_tally_rx_pkg.sv
package edge_tally_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_WIN  = 2'd2
  } rx_state_e;

  // Clamp a requested frame length to the word width.
  function automatic int clamp_len(input int req, input int max_bits);
    return (req > max_bits) ? max_bits : req;
  endfunction

  // Open band test: strictly inside (lo, hi) decodes as a one.
  function automatic logic band_hit(input int cnt, input int lo, input int hi);
    return (cnt > lo) && (cnt < hi);
  endfunction

endpackage

// File: rtl/edge_tally_rx_sync.sv
module edge_tally_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_seen
);
  logic [STAGES-1:0] sreg;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg   <= '0;
      last_q <= 1'b0;
    end else begin
      sreg   <= {sreg[STAGES-2:0], din};
      last_q <= sreg[STAGES-1];
    end
  end

  // Either direction of change counts.
  assign edge_seen = sreg[STAGES-1] ^ last_q;
endmodule

// File: rtl/edge_tally_rx_seq.sv
module edge_tally_rx_seq
  import edge_tally_rx_pkg::*;
#(
  parameter int MAX_BITS     = 16,
  parameter int REQ_W        = 5,
  parameter int WAIT_TICKS   = 490,
  parameter int WINDOW_TICKS = 150,
  localparam int LEN_W  = $clog2(MAX_BITS + 1),
  localparam int IDX_W  = $clog2(MAX_BITS),
  localparam int TICK_W = $clog2(((WAIT_TICKS > WINDOW_TICKS) ? WAIT_TICKS : WINDOW_TICKS) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REQ_W-1:0] req_bits,
  input  logic             tick_en,
  output logic             launch,
  output logic [LEN_W-1:0] launch_len,
  output logic             busy,
  output logic             in_win,
  output logic             win_end,
  output logic             frame_end,
  output logic [IDX_W-1:0] bit_idx
);
  rx_state_e         state_q;
  logic [TICK_W-1:0] tcnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LEN_W-1:0]  len_q;
  logic              wait_last;
  logic              win_last;
  logic              last_bit;

  assign launch_len = LEN_W'(clamp_len(int'(req_bits), MAX_BITS));
  assign launch     = (state_q == ST_IDLE) && start;
  assign busy       = (state_q != ST_IDLE);
  assign in_win     = (state_q == ST_WIN);
  assign wait_last  = tick_en && (tcnt_q == TICK_W'(WAIT_TICKS - 1));
  assign win_last   = tick_en && (tcnt_q == TICK_W'(WINDOW_TICKS - 1));
  assign win_end    = in_win && win_last;
  assign last_bit   = (LEN_W'(idx_q) == (len_q - LEN_W'(1)));
  assign frame_end  = (win_end && last_bit) || (launch && (launch_len == '0));
  assign bit_idx    = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      idx_q   <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            len_q   <= launch_len;
            tcnt_q  <= '0;
            idx_q   <= '0;
            state_q <= (launch_len == '0) ? ST_IDLE : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (wait_last) begin
            tcnt_q  <= '0;
            state_q <= ST_WIN;
          end else if (tick_en) begin
            tcnt_q <= tcnt_q + TICK_W'(1);
          end
        end
        ST_WIN: begin
          if (win_last) begin
            tcnt_q <= '0;
            if (last_bit) state_q <= ST_IDLE;
            else          idx_q   <= idx_q + IDX_W'(1);
          end else if (tick_en) begin
            tcnt_q <= tcnt_q + TICK_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/edge_tally_rx_tally.sv
module edge_tally_rx_tally
  import edge_tally_rx_pkg::*;
#(
  parameter int BAND_LO = 20,
  parameter int BAND_HI = 60,
  localparam int EDGE_W = $clog2(BAND_HI + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_seen,
  input  logic              in_win,
  input  logic              win_end,
  output logic [EDGE_W-1:0] edge_cnt,
  output logic              bit_val
);
  localparam logic [EDGE_W-1:0] EDGE_MAX = '1;

  logic [EDGE_W-1:0] cnt_q;
  logic [EDGE_W-1:0] cnt_nxt;

  // Saturating increment; nothing is counted outside a window.
  always_comb begin
    cnt_nxt = cnt_q;
    if (!in_win)                            cnt_nxt = '0;
    else if (edge_seen && cnt_q != EDGE_MAX) cnt_nxt = cnt_q + EDGE_W'(1);
  end

  assign bit_val  = band_hit(int'(cnt_nxt), BAND_LO, BAND_HI);
  assign edge_cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (win_end) cnt_q <= '0;
    else              cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/edge_tally_rx_word.sv
module edge_tally_rx_word #(
  parameter int MAX_BITS = 16,
  localparam int LEN_W = $clog2(MAX_BITS + 1),
  localparam int IDX_W = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic [LEN_W-1:0]    launch_len,
  input  logic                win_end,
  input  logic [IDX_W-1:0]    bit_idx,
  input  logic                bit_val,
  input  logic                frame_end,
  output logic [MAX_BITS-1:0] data_o,
  output logic [LEN_W-1:0]    nbits_o,
  output logic                done_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      nbits_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= frame_end;
      if (launch) begin
        data_o  <= '0;
        nbits_o <= launch_len;
      end else if (win_end) begin
        data_o[bit_idx] <= bit_val;
      end
    end
  end
endmodule

// File: rtl/edge_tally_rx.sv
module edge_tally_rx #(
  parameter int MAX_BITS     = 16,
  parameter int REQ_W        = 5,
  parameter int WAIT_TICKS   = 490,
  parameter int WINDOW_TICKS = 150,
  parameter int BAND_LO      = 20,
  parameter int BAND_HI      = 60,
  parameter int SYNC_STAGES  = 2,
  localparam int LEN_W  = $clog2(MAX_BITS + 1),
  localparam int IDX_W  = $clog2(MAX_BITS),
  localparam int EDGE_W = $clog2(BAND_HI + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [REQ_W-1:0]    req_bits,
  input  logic                tick_en,
  input  logic                rx_in,
  output logic [MAX_BITS-1:0] data_o,
  output logic [LEN_W-1:0]    nbits_o,
  output logic                done_o
);
  // Named internal events, brought out for the checker.
  logic              edge_seen;
  logic              launch;
  logic [LEN_W-1:0]  launch_len;
  logic              busy;
  logic              in_win;
  logic              win_end;
  logic              frame_end;
  logic [IDX_W-1:0]  bit_idx;
  logic [EDGE_W-1:0] edge_cnt;
  logic              bit_val;

  edge_tally_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_in), .edge_seen(edge_seen)
  );

  edge_tally_rx_seq #(
    .MAX_BITS(MAX_BITS), .REQ_W(REQ_W),
    .WAIT_TICKS(WAIT_TICKS), .WINDOW_TICKS(WINDOW_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .req_bits(req_bits),
    .tick_en(tick_en), .launch(launch), .launch_len(launch_len),
    .busy(busy), .in_win(in_win), .win_end(win_end),
    .frame_end(frame_end), .bit_idx(bit_idx)
  );

  edge_tally_rx_tally #(.BAND_LO(BAND_LO), .BAND_HI(BAND_HI)) u_tally (
    .clk(clk), .rst_n(rst_n), .edge_seen(edge_seen), .in_win(in_win),
    .win_end(win_end), .edge_cnt(edge_cnt), .bit_val(bit_val)
  );

  edge_tally_rx_word #(.MAX_BITS(MAX_BITS)) u_word (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_len(launch_len),
    .win_end(win_end), .bit_idx(bit_idx), .bit_val(bit_val),
    .frame_end(frame_end), .data_o(data_o), .nbits_o(nbits_o),
    .done_o(done_o)
  );
endmodule

// File: rtl/edge_tally_rx_chk.sv
module edge_tally_rx_chk #(
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = 5,
  parameter int EDGE_W   = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                busy,
  input logic                in_win,
  input logic                frame_end,
  input logic [EDGE_W-1:0]   edge_cnt,
  input logic [MAX_BITS-1:0] data_o,
  input logic [LEN_W-1:0]    nbits_o,
  input logic                done_o
);
  localparam logic [EDGE_W-1:0] EDGE_TOP = '1;

  AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    nbits_o <= LEN_W'(MAX_BITS)); // R5

  AST_QUIET_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> (edge_cnt == '0)); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(data_o) && $stable(nbits_o))); // R7

  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_o); // R2

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !frame_end) |=> busy); // R9

  AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_cnt == EDGE_TOP) |=> (edge_cnt == EDGE_TOP || edge_cnt == '0)); // R11
endmodule

bind edge_tally_rx edge_tally_rx_chk #(
  .MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .EDGE_W(EDGE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .in_win(in_win),
  .frame_end(frame_end), .edge_cnt(edge_cnt), .data_o(data_o),
  .nbits_o(nbits_o), .done_o(done_o)
);

// File: tb/edge_tally_rx_bench.sv
`timescale 1ns/1ps
module edge_tally_rx_bench;
  localparam int WAITT = 490;
  localparam int WINT  = 150;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  req_bits = '0;
  logic        tick_en = 1'b1;
  logic        rx_in = 1'b0;
  logic [15:0] data_o;
  logic [4:0]  nbits_o;
  logic        done_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int done_cnt = 0;
  int done_cyc = 0;
  logic [15:0] cap_data = '0;
  bit half_rate = 1'b0;
  int edges_q [16];

  edge_tally_rx u_edge_tally_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .req_bits(req_bits),
    .tick_en(tick_en), .rx_in(rx_in), .data_o(data_o),
    .nbits_o(nbits_o), .done_o(done_o)
  );

  always #2 clk = ~clk; // 250 MHz

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (done_o) begin
      done_cnt = done_cnt + 1;
      done_cyc = cyc;
      cap_data = data_o;
    end
  end

  // Tick generator: full rate or every other cycle.
  initial begin
    forever begin
      @(negedge clk);
      tick_en = half_rate ? ~tick_en : 1'b1;
    end
  end

  initial begin
    #(200000 * 4);
    total = total + 1;
    bad = bad + 1;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent statement of the decode rule.
  function automatic logic exp_bit(input int n);
    return (n >= 21) && (n <= 59);
  endfunction

  // Runs one frame and checks its outcome.
  task automatic run_frame(input string req, input int req_len, input int scale,
                           input bit wait_noise, input bit busy_poke);
    int len;
    int c0;
    logic [15:0] exp_data;
    len = (req_len > 16) ? 16 : req_len;
    exp_data = '0;
    for (int w = 0; w < len; w++) exp_data[w] = exp_bit(edges_q[w]);
    done_cnt = 0;
    @(negedge clk);
    req_bits = 5'(req_len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c0 = cyc;
    check({req, " nbits"}, int'(nbits_o), len);
    if (len > 0) begin
      for (int k = 0; k < WAITT * scale + 10; k++) begin
        if (wait_noise && k >= 100 && k < 140) rx_in = ~rx_in;
        @(negedge clk);
      end
      for (int w = 0; w < len; w++) begin
        for (int k = 0; k < WINT * scale; k++) begin
          if (k < edges_q[w]) rx_in = ~rx_in;
          start = (busy_poke && w == 1 && k == 50);
          @(negedge clk);
        end
      end
    end
    start = 1'b0;
    repeat (20) @(negedge clk);
    check({req, " done pulses"}, done_cnt, 1);
    check({req, " data at done"}, int'(cap_data), int'(exp_data));
    check({req, " data held"}, int'(data_o), int'(exp_data));
    if (scale == 1)
      check({req, " done cycle"}, done_cyc - c0, (len == 0) ? 0 : WAITT + WINT * len);
  endtask

  task automatic clear_edges();
    for (int i = 0; i < 16; i++) edges_q[i] = 0;
  endtask

  task automatic t_reset();
    #1;
    check("R1 done in reset", int'(done_o), 0);
    check("R1 data in reset", int'(data_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", int'(done_o), 0);
    check("R1 nbits after reset", int'(nbits_o), 0);
  endtask

  task automatic t_band();
    clear_edges();
    edges_q[0] = 0;  edges_q[1] = 20; edges_q[2] = 21; edges_q[3] = 42;
    edges_q[4] = 59; edges_q[5] = 60; edges_q[6] = 42;
    run_frame("R3 band edges R2 timing", 7, 1, 1'b0, 1'b0);
  endtask

  task automatic t_lsb_first();
    clear_edges();
    edges_q[0] = 42; edges_q[1] = 42; edges_q[2] = 0; edges_q[3] = 42;
    run_frame("R4 lsb-first R8 upper zero", 4, 1, 1'b0, 1'b0);
  endtask

  task automatic t_clamp();
    clear_edges();
    for (int i = 0; i < 16; i++) edges_q[i] = (i % 3 == 0) ? 40 : 5;
    run_frame("R5 clamp 31", 31, 1, 1'b0, 1'b0);
  endtask

  task automatic t_zero_len();
    clear_edges();
    run_frame("R5 zero length", 0, 1, 1'b0, 1'b0);
  endtask

  task automatic t_wait_noise();
    clear_edges();
    edges_q[2] = 30;
    run_frame("R6 wait noise", 4, 1, 1'b1, 1'b0);
  endtask

  task automatic t_busy_start();
    clear_edges();
    edges_q[0] = 25; edges_q[2] = 50;
    run_frame("R9 start while busy", 3, 1, 1'b0, 1'b1);
  endtask

  task automatic t_half_rate();
    clear_edges();
    edges_q[0] = 30; edges_q[1] = 0; edges_q[2] = 45;
    half_rate = 1'b1;
    run_frame("R10 half tick rate", 3, 2, 1'b0, 1'b0);
    half_rate = 1'b0;
  endtask

  task automatic t_saturate();
    clear_edges();
    edges_q[0] = 100; edges_q[1] = 42;
    run_frame("R11 saturation", 2, 1, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_band();
    t_lsb_first();
    t_clamp();
    t_zero_len();
    t_wait_noise();
    t_busy_start();
    t_half_rate();
    t_saturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule